// File: doc/BRIEF.md
# Register Rename Map with Buffer-Ready Flag

This block keeps, for every architectural register, a record of where the register's newest value lives. The record has a producer tag and a single flag. A tag of zero means the committed register file holds the value. A nonzero tag means an in-flight instruction owns the register; that instruction is identified by its reorder-buffer slot. The flag tells whether that producer has already written its result into the reorder buffer.

Dispatch uses two combinational source lookups and one destination write per cycle. The completion stage sends the tag of each finished instruction, and the retire stage sends the register and tag of each committed instruction. The table ignores either update once a younger dispatch has taken over the register. A flush returns every register to the register file, for example after an exception reaches the head of the reorder buffer. The table stores no data values.

Top module: `rename_map`

## Requirements
- R1: After reset every register reads with tag 0 and location code 0 (register file).
- R2: A source lookup returns location code 0 when the tag is 0, code 1 when the tag is nonzero and the flag is clear (result pending), and code 2 when the flag is set (result waiting in the reorder buffer). Code 3 never appears.
- R3: When `disp_en` is high, the entry for `disp_reg` holds `disp_tag` with a clear flag from the next cycle on.
- R4: Source lookups are combinational on the table state held before the current edge, so a destination written in the same cycle is not visible to that cycle's lookups.
- R5: A completion with a nonzero `cmpl_tag` sets the flag only in an entry whose tag equals `cmpl_tag`. An entry that has since been re-mapped to another tag is left unchanged, and a completion tag of 0 changes nothing.
- R6: A retire clears the entry `ret_reg` to tag 0 only if the entry still holds `ret_tag`. In every other case the entry is unchanged.
- R7: When a dispatch write and a completion or retire update hit the same entry in one cycle, the dispatch write is the one that takes effect.
- R8: `flush` clears every entry to tag 0 with a clear flag on the next cycle, and it overrides any other update in that cycle.
- R9: With `HARDWIRE_ZERO` set, register 0 always reads tag 0 and code 0, and dispatches to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Clear all mappings |
| src_a_reg | input | RW | First source register number |
| src_a_tag | output | TAG_W | First source producer tag |
| src_a_loc | output | 2 | First source location code |
| src_b_reg | input | RW | Second source register number |
| src_b_tag | output | TAG_W | Second source producer tag |
| src_b_loc | output | 2 | Second source location code |
| disp_en | input | 1 | Destination write strobe |
| disp_reg | input | RW | Destination register number |
| disp_tag | input | TAG_W | New reorder-buffer tag for the destination (nonzero) |
| cmpl_en | input | 1 | Completion strobe |
| cmpl_tag | input | TAG_W | Tag of the completing instruction |
| ret_en | input | 1 | Retire strobe |
| ret_reg | input | RW | Destination register of the retiring instruction |
| ret_tag | input | TAG_W | Tag of the retiring instruction |

## Verification
The bench targets stale updates. These are a completion or retire for a tag that a younger dispatch has already replaced. A table that skipped the tag comparison would mark the younger producer as ready, or send its consumers to the register file too early. The bench also collides a dispatch with a retire and a completion on the same register, and a dispatch with a flush. A wrong priority there would leave a cleared entry or a set flag on the newest mapping. It also reads a register in the same cycle that register is renamed, which exposes a write-through path that would hand an instruction its own tag.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
   typedef enum logic [1:0] {
      LOC_REGFILE = 2'd0,
      LOC_PENDING = 2'd1,
      LOC_BUFFER  = 2'd2
   } opnd_loc_e;
endpackage

// File: rtl/rmap_entry.sv
module rmap_entry #(
   parameter int TAG_W    = 4,
   parameter int HARDWIRE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             disp_hit,
   input  logic [TAG_W-1:0] disp_tag,
   input  logic             cmpl_en,
   input  logic [TAG_W-1:0] cmpl_tag,
   input  logic             ret_hit,
   input  logic [TAG_W-1:0] ret_tag,
   output logic [TAG_W-1:0] tag_o,
   output logic             rdy_o
);
   generate
      if (HARDWIRE != 0) begin : g_const
         logic unused_in;
         assign unused_in = ^{clk, rst_n, flush, disp_hit, disp_tag,
                              cmpl_en, cmpl_tag, ret_hit, ret_tag};
         assign tag_o = '0;
         assign rdy_o = 1'b0;
      end else begin : g_store
         logic [TAG_W-1:0] tag_q;
         logic             rdy_q;
         logic             cmpl_match, ret_match;

         assign cmpl_match = cmpl_en && (cmpl_tag != '0) && (tag_q == cmpl_tag);
         assign ret_match  = ret_hit && (tag_q != '0) && (tag_q == ret_tag);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tag_q <= '0;
               rdy_q <= 1'b0;
            end else if (flush) begin
               tag_q <= '0;
               rdy_q <= 1'b0;
            end else if (disp_hit) begin
               tag_q <= disp_tag;
               rdy_q <= 1'b0;
            end else if (ret_match) begin
               tag_q <= '0;
               rdy_q <= 1'b0;
            end else if (cmpl_match) begin
               rdy_q <= 1'b1;
            end
         end

         assign tag_o = tag_q;
         assign rdy_o = rdy_q;
      end
   endgenerate
endmodule

// File: rtl/rmap_rdport.sv
module rmap_rdport
   import rmap_pkg::*;
#(
   parameter int NREGS = 32,
   parameter int TAG_W = 4,
   parameter int RW    = 5
) (
   input  logic [NREGS-1:0][TAG_W-1:0] tags,
   input  logic [NREGS-1:0]            rdys,
   input  logic [RW-1:0]               sel,
   output logic [TAG_W-1:0]            tag_o,
   output opnd_loc_e                   loc_o
);
   logic in_range;
   logic rdy_sel;

   assign in_range = (int'(sel) < NREGS);

   always_comb begin
      tag_o   = '0;
      rdy_sel = 1'b0;
      if (in_range) begin
         tag_o   = tags[sel];
         rdy_sel = rdys[sel];
      end
      if (rdy_sel)           loc_o = LOC_BUFFER;
      else if (tag_o == '0)  loc_o = LOC_REGFILE;
      else                   loc_o = LOC_PENDING;
   end
endmodule

// File: rtl/rename_map.sv
module rename_map
   import rmap_pkg::*;
#(
   parameter int NUM_REGS      = 32,
   parameter int TAG_W         = 4,
   parameter int HARDWIRE_ZERO = 1,
   localparam int RW           = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [RW-1:0]    src_a_reg,
   output logic [TAG_W-1:0] src_a_tag,
   output logic [1:0]       src_a_loc,
   input  logic [RW-1:0]    src_b_reg,
   output logic [TAG_W-1:0] src_b_tag,
   output logic [1:0]       src_b_loc,
   input  logic             disp_en,
   input  logic [RW-1:0]    disp_reg,
   input  logic [TAG_W-1:0] disp_tag,
   input  logic             cmpl_en,
   input  logic [TAG_W-1:0] cmpl_tag,
   input  logic             ret_en,
   input  logic [RW-1:0]    ret_reg,
   input  logic [TAG_W-1:0] ret_tag
);
   generate
      if (NUM_REGS < 2) begin : g_bad_regs
         $error("rename_map: NUM_REGS must be at least 2");
      end
      if (TAG_W < 2) begin : g_bad_tag
         $error("rename_map: TAG_W must be at least 2");
      end
      if (HARDWIRE_ZERO != 0 && HARDWIRE_ZERO != 1) begin : g_bad_zero
         $error("rename_map: HARDWIRE_ZERO must be 0 or 1");
      end
   endgenerate

   logic [NUM_REGS-1:0][TAG_W-1:0] ent_tag;
   logic [NUM_REGS-1:0]            ent_rdy;
   opnd_loc_e                      loc_a, loc_b;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
      logic disp_hit, ret_hit;
      assign disp_hit = disp_en && (disp_reg == RW'(i));
      assign ret_hit  = ret_en  && (ret_reg  == RW'(i));

      rmap_entry #(
         .TAG_W    (TAG_W),
         .HARDWIRE ((HARDWIRE_ZERO != 0 && i == 0) ? 1 : 0)
      ) u_ent (
         .clk      (clk),
         .rst_n    (rst_n),
         .flush    (flush),
         .disp_hit (disp_hit),
         .disp_tag (disp_tag),
         .cmpl_en  (cmpl_en),
         .cmpl_tag (cmpl_tag),
         .ret_hit  (ret_hit),
         .ret_tag  (ret_tag),
         .tag_o    (ent_tag[i]),
         .rdy_o    (ent_rdy[i])
      );
   end

   rmap_rdport #(.NREGS(NUM_REGS), .TAG_W(TAG_W), .RW(RW)) u_rd_a (
      .tags  (ent_tag),
      .rdys  (ent_rdy),
      .sel   (src_a_reg),
      .tag_o (src_a_tag),
      .loc_o (loc_a)
   );

   rmap_rdport #(.NREGS(NUM_REGS), .TAG_W(TAG_W), .RW(RW)) u_rd_b (
      .tags  (ent_tag),
      .rdys  (ent_rdy),
      .sel   (src_b_reg),
      .tag_o (src_b_tag),
      .loc_o (loc_b)
   );

   assign src_a_loc = loc_a;
   assign src_b_loc = loc_b;
endmodule

// File: rtl/rmap_chk.sv
module rmap_chk #(
   parameter int NUM_REGS      = 32,
   parameter int TAG_W         = 4,
   parameter int HARDWIRE_ZERO = 1,
   localparam int RW           = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           flush,
   input logic [RW-1:0]                  src_a_reg,
   input logic [TAG_W-1:0]               src_a_tag,
   input logic [1:0]                     src_a_loc,
   input logic [1:0]                     src_b_loc,
   input logic                           disp_en,
   input logic [RW-1:0]                  disp_reg,
   input logic [TAG_W-1:0]               disp_tag,
   input logic                           cmpl_en,
   input logic [TAG_W-1:0]               cmpl_tag,
   input logic                           ret_en,
   input logic [RW-1:0]                  ret_reg,
   input logic [TAG_W-1:0]               ret_tag,
   input logic [NUM_REGS-1:0][TAG_W-1:0] ent_tag,
   input logic [NUM_REGS-1:0]            ent_rdy
);
   // R2
   loc_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_a_loc != 2'd3) && (src_b_loc != 2'd3));

   // R2
   loc_matches_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_tag[src_a_reg] == '0) |-> (src_a_loc == 2'd0 && src_a_tag == '0));

   // R3 and R7: a dispatch lands even when completion or retire hits the same entry
   disp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_en && !flush && !(HARDWIRE_ZERO != 0 && disp_reg == '0)) |=>
      (ent_tag[$past(disp_reg)] == $past(disp_tag) && !ent_rdy[$past(disp_reg)]));

   // R5
   flag_needs_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(ent_rdy & ~$past(ent_rdy))) |-> ($past(cmpl_en) && $past(cmpl_tag) != '0));

   // R8
   flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (ent_tag == '0 && ent_rdy == '0));

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_ret
      // R6
      ret_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(ent_tag[i]) != '0 && ent_tag[i] == '0) |->
         ($past(flush) || ($past(ret_en) && $past(ret_reg) == RW'(i) &&
                           $past(ret_tag) == $past(ent_tag[i]))));
   end

   generate
      if (HARDWIRE_ZERO != 0) begin : g_zero
         // R9
         zero_reg_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ent_tag[0] == '0) && !ent_rdy[0]);
      end
   endgenerate
endmodule

bind rename_map rmap_chk #(
   .NUM_REGS      (NUM_REGS),
   .TAG_W         (TAG_W),
   .HARDWIRE_ZERO (HARDWIRE_ZERO)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .flush     (flush),
   .src_a_reg (src_a_reg),
   .src_a_tag (src_a_tag),
   .src_a_loc (src_a_loc),
   .src_b_loc (src_b_loc),
   .disp_en   (disp_en),
   .disp_reg  (disp_reg),
   .disp_tag  (disp_tag),
   .cmpl_en   (cmpl_en),
   .cmpl_tag  (cmpl_tag),
   .ret_en    (ret_en),
   .ret_reg   (ret_reg),
   .ret_tag   (ret_tag),
   .ent_tag   (ent_tag),
   .ent_rdy   (ent_rdy)
);

// File: tb/sim_rename_map.sv
`timescale 1ns/1ps
module sim_rename_map;
   localparam int NR = 32;
   localparam int TW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush = 1'b0;
   logic [4:0]    src_a_reg = '0, src_b_reg = '0;
   logic [TW-1:0] src_a_tag, src_b_tag;
   logic [1:0]    src_a_loc, src_b_loc;
   logic          disp_en = 1'b0, cmpl_en = 1'b0, ret_en = 1'b0;
   logic [4:0]    disp_reg = '0, ret_reg = '0;
   logic [TW-1:0] disp_tag = '0, cmpl_tag = '0, ret_tag = '0;

   int  nchk = 0;
   int  nerr = 0;
   bit  done = 1'b0;
   int  m_tag [NR];
   bit  m_rdy [NR];

   always #5 clk = ~clk;

   rename_map #(.NUM_REGS(NR), .TAG_W(TW), .HARDWIRE_ZERO(1)) u0 (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .src_a_reg(src_a_reg), .src_a_tag(src_a_tag), .src_a_loc(src_a_loc),
      .src_b_reg(src_b_reg), .src_b_tag(src_b_tag), .src_b_loc(src_b_loc),
      .disp_en(disp_en), .disp_reg(disp_reg), .disp_tag(disp_tag),
      .cmpl_en(cmpl_en), .cmpl_tag(cmpl_tag),
      .ret_en(ret_en), .ret_reg(ret_reg), .ret_tag(ret_tag));

   task automatic chk(string rq, string what, int act, int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   function automatic int mloc(int r);
      if (m_rdy[r]) return 2;
      if (m_tag[r] == 0) return 0;
      return 1;
   endfunction

   // reference update, priority: flush, dispatch, matching retire, matching completion
   function automatic void model_edge(bit de, int dr, int dt, bit ce, int ct,
                                      bit re, int rr, int rt, bit fl);
      for (int i = 0; i < NR; i++) begin
         if (fl) begin
            m_tag[i] = 0; m_rdy[i] = 1'b0;
         end else if (de && dr == i && i != 0) begin
            m_tag[i] = dt; m_rdy[i] = 1'b0;
         end else if (re && rr == i && m_tag[i] != 0 && m_tag[i] == rt) begin
            m_tag[i] = 0; m_rdy[i] = 1'b0;
         end else if (ce && ct != 0 && m_tag[i] == ct) begin
            m_rdy[i] = 1'b1;
         end
      end
   endfunction

   // one cycle: drive, compare lookups against the pre-edge model (R4), then advance
   task automatic cyc(bit de, int dr, int dt, bit ce, int ct,
                      bit re, int rr, int rt, bit fl, int ra, int rb);
      @(negedge clk);
      disp_en = de; disp_reg = 5'(dr); disp_tag = TW'(dt);
      cmpl_en = ce; cmpl_tag = TW'(ct);
      ret_en = re; ret_reg = 5'(rr); ret_tag = TW'(rt);
      flush = fl; src_a_reg = 5'(ra); src_b_reg = 5'(rb);
      #1;
      chk("R4", "src_a tag", int'(src_a_tag), m_tag[ra]);
      chk("R2", "src_a loc", int'(src_a_loc), mloc(ra));
      chk("R4", "src_b tag", int'(src_b_tag), m_tag[rb]);
      chk("R2", "src_b loc", int'(src_b_loc), mloc(rb));
      @(posedge clk);
      model_edge(de, dr, dt, ce, ct, re, rr, rt, fl);
   endtask

   task automatic expect_reg(int r, int etag, int eloc, string rq);
      @(negedge clk);
      disp_en = 1'b0; cmpl_en = 1'b0; ret_en = 1'b0; flush = 1'b0;
      src_a_reg = 5'(r);
      #1;
      chk(rq, $sformatf("reg %0d tag", r), int'(src_a_tag), etag);
      chk(rq, $sformatf("reg %0d loc", r), int'(src_a_loc), eloc);
   endtask

   initial begin
      for (int i = 0; i < NR; i++) begin m_tag[i] = 0; m_rdy[i] = 1'b0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1
      expect_reg(0, 0, 0, "R1");
      expect_reg(5, 0, 0, "R1");
      expect_reg(31, 0, 0, "R1");
      // R4: rename r5 while reading r5, lookup still shows register file
      cyc(1, 5, 3, 0, 0, 0, 0, 0, 0, 5, 5);
      expect_reg(5, 3, 1, "R3");
      cyc(1, 6, 4, 0, 0, 0, 0, 0, 0, 6, 5);
      cyc(0, 0, 0, 1, 3, 0, 0, 0, 0, 5, 6);
      expect_reg(5, 3, 2, "R5");
      expect_reg(6, 4, 1, "R5");
      // stale completion after re-mapping
      cyc(1, 5, 7, 0, 0, 0, 0, 0, 0, 5, 6);
      cyc(0, 0, 0, 1, 3, 0, 0, 0, 0, 5, 6);
      expect_reg(5, 7, 1, "R5");
      cyc(0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 2);
      expect_reg(1, 0, 0, "R5");
      // stale retire, then matching retire
      cyc(0, 0, 0, 0, 0, 1, 5, 3, 0, 5, 5);
      expect_reg(5, 7, 1, "R6");
      cyc(0, 0, 0, 0, 0, 1, 5, 7, 0, 5, 5);
      expect_reg(5, 0, 0, "R6");
      // dispatch collides with retire and completion on r8
      cyc(1, 8, 2, 0, 0, 0, 0, 0, 0, 8, 8);
      cyc(1, 8, 10, 1, 10, 1, 8, 2, 0, 8, 8);
      expect_reg(8, 10, 1, "R7");
      // flush together with a dispatch
      cyc(1, 9, 5, 0, 0, 0, 0, 0, 1, 8, 6);
      expect_reg(8, 0, 0, "R8");
      expect_reg(9, 0, 0, "R8");
      expect_reg(6, 0, 0, "R8");
      // zero register
      cyc(1, 0, 6, 0, 0, 0, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 1, 6, 0, 0, 0, 0, 0, 0);
      expect_reg(0, 0, 0, "R9");
      // random traffic compared cycle by cycle
      for (int n = 0; n < 600; n++) begin
         int rr;
         int rt;
         rr = int'($urandom_range(NR - 1));
         rt = ($urandom_range(1) == 1) ? m_tag[rr] : int'($urandom_range(15));
         cyc($urandom_range(1) == 1, int'($urandom_range(NR - 1)), int'($urandom_range(15, 1)),
             $urandom_range(9) < 4, int'($urandom_range(15)),
             $urandom_range(9) < 3, rr, rt,
             $urandom_range(49) == 0,
             int'($urandom_range(NR - 1)), int'($urandom_range(NR - 1)));
      end
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1'b1;
         nchk++;
         nerr++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end
endmodule